// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Control

This block is the hazard controller for a five-stage, in-order pipeline. It looks at the register numbers and control flags held in the pipeline registers between fetch, decode, execute, memory and write-back. For each ALU operand in the execute stage it picks where the value comes from: the register file, the result waiting in the execute/memory register, or the result waiting in the memory/write-back register.

It also finds the one dependence that forwarding cannot cover. That case is an instruction in decode that reads the destination of a load now in execute. The block then freezes the PC and the fetch/decode register for one cycle and turns the instruction entering execute into a bubble. When a jump is decoded, or a branch resolved in decode is taken against the not-taken guess, it zeroes the fetched instruction. That costs one slot.

The datapath multiplexers, the register file, the ALU and the memories live elsewhere. The block supplies only their select and enable lines.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each operand select is 2 bits wide. 2'b00 picks the register-file value, 2'b10 the execute/memory result, and 2'b01 the memory/write-back result. The value 2'b11 never appears.
- R2: Operand A selects 2'b10 when `exm_wr` is 1, `exm_rd` is nonzero and `exm_rd` equals `idex_rs`. Operand B does the same against `idex_rt`. With `exm_wr` at 0, that path is not taken.
- R3: Register number 0 is never forwarded from either stage. A destination of 0 leaves the select at 2'b00.
- R4: An operand selects 2'b01 when `mwb_wr` is 1, `mwb_rd` is nonzero and `mwb_rd` matches its source, but only if the execute/memory path of R2 is not taken for that operand. When both stages qualify, 2'b10 wins. This path also delivers a loaded value to its consumer once the stall of R6 is over.
- R5: The two operands are decided separately, so A and B may carry different selects in the same cycle.
- R6: A stall is requested when `idex_memrd` is 1 and `idex_rt` equals `ifid_rs` or `ifid_rt`. Register 0 is not excluded from this test.
- R7: While stalling, `pc_we` and `ifid_we` are 0 and `idex_bubble` is 1. Otherwise `pc_we` and `ifid_we` are 1 and `idex_bubble` is 0.
- R8: A stall never lasts two cycles in a row, even if the stall request of R6 is still present in the next cycle. Reset clears the memory of the previous stall.
- R9: `ifid_flush` is 1 in any cycle where `jump_id` or `brtaken_id` is 1 and no stall occurs. `pc_we` stays 1 in that cycle.
- R10: A stall overrides a flush in the same cycle. A redirect that is still present when the stalled instruction moves on raises `ifid_flush` in that later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ifid_rs | input | REG_W | First source register of the decode-stage instruction |
| ifid_rt | input | REG_W | Second source register of the decode-stage instruction |
| idex_rs | input | REG_W | First source register of the execute-stage instruction |
| idex_rt | input | REG_W | Second source register (load destination) of the execute-stage instruction |
| idex_memrd | input | 1 | Execute-stage instruction reads memory (load) |
| exm_wr | input | 1 | Execute/memory instruction writes a register |
| exm_rd | input | REG_W | Execute/memory destination register |
| mwb_wr | input | 1 | Memory/write-back instruction writes a register |
| mwb_rd | input | REG_W | Memory/write-back destination register |
| jump_id | input | 1 | Jump decoded in the decode stage |
| brtaken_id | input | 1 | Branch resolved taken in the decode stage |
| fwd_a | output | 2 | Source select for ALU operand A |
| fwd_b | output | 2 | Source select for ALU operand B |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Force zero control fields into the execute stage |
| ifid_flush | output | 1 | Zero the fetched instruction |

## Verification
The checker watches a set of rules on every cycle. The selects stay legal and never point at register 0. A qualified execute/memory match always gets priority. The freeze and bubble lines move together. No stall follows a stall, and no flush comes out during one.

Some behaviour only the directed scenarios can show. These are the exact select chosen for each pattern of matching and disabled stages, and the split of A and B within one cycle. They also cover the load with a zero destination, and the sequence in which a redirect suppressed by a stall comes back one cycle later.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MWB = 2'b01,
    SRC_EXM = 2'b10
  } src_sel_e;

  // A producing stage is usable when it writes, its target is nonzero
  // and its target is the register the consumer reads.
  function automatic logic dest_hit(input logic wr, input logic zero_dest,
                                    input logic same_reg);
    return wr && !zero_dest && same_reg;
  endfunction

  // The newer result wins when both producers are usable.
  function automatic src_sel_e pick_src(input logic exm_hit, input logic mwb_hit);
    if (exm_hit)      return SRC_EXM;
    else if (mwb_hit) return SRC_MWB;
    else              return SRC_RF;
  endfunction

  // A load in execute blocks a decode instruction that reads its target.
  function automatic logic load_clash(input logic is_load, input logic rs_same,
                                      input logic rt_same);
    return is_load && (rs_same || rt_same);
  endfunction

endpackage

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             exm_wr,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             mwb_wr,
  input  logic [REG_W-1:0] mwb_rd,
  output src_sel_e         sel
);
  logic exm_hit;
  logic mwb_hit;

  assign exm_hit = dest_hit(exm_wr, exm_rd == '0, exm_rd == src);
  assign mwb_hit = dest_hit(mwb_wr, mwb_rd == '0, mwb_rd == src);
  assign sel     = pick_src(exm_hit, mwb_hit);
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idex_memrd,
  input  logic [REG_W-1:0] idex_rt,
  input  logic [REG_W-1:0] ifid_rs,
  input  logic [REG_W-1:0] ifid_rt,
  output logic             stall
);
  logic clash;
  logic stall_q;

  assign clash = load_clash(idex_memrd, idex_rt == ifid_rs, idex_rt == ifid_rt);
  // Only one frozen cycle per load: a clash seen again right after a
  // stall is the same load and must let the pipe move.
  assign stall = clash && !stall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;
  end
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect (
  input  logic jump_id,
  input  logic brtaken_id,
  input  logic stall,
  output logic redir,
  output logic flush
);
  assign redir = jump_id || brtaken_id;
  assign flush = redir && !stall;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ifid_rs,
  input  logic [REG_W-1:0] ifid_rt,
  input  logic [REG_W-1:0] idex_rs,
  input  logic [REG_W-1:0] idex_rt,
  input  logic             idex_memrd,
  input  logic             exm_wr,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             mwb_wr,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             jump_id,
  input  logic             brtaken_id,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_bubble,
  output logic             ifid_flush
);
  localparam int NUM_OPS = 2;

  logic [REG_W-1:0] op_src [NUM_OPS];
  src_sel_e         op_sel [NUM_OPS];
  logic             stall_w;
  logic             redir_w;

  assign op_src[0] = idex_rs;
  assign op_src[1] = idex_rt;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hz_operand_sel #(.REG_W(REG_W)) u_sel (
      .src    (op_src[g]),
      .exm_wr (exm_wr),
      .exm_rd (exm_rd),
      .mwb_wr (mwb_wr),
      .mwb_rd (mwb_rd),
      .sel    (op_sel[g])
    );
  end

  hz_load_use #(.REG_W(REG_W)) u_lu (
    .clk        (clk),
    .rst_n      (rst_n),
    .idex_memrd (idex_memrd),
    .idex_rt    (idex_rt),
    .ifid_rs    (ifid_rs),
    .ifid_rt    (ifid_rt),
    .stall      (stall_w)
  );

  hz_redirect u_redir (
    .jump_id    (jump_id),
    .brtaken_id (brtaken_id),
    .stall      (stall_w),
    .redir      (redir_w),
    .flush      (ifid_flush)
  );

  assign fwd_a       = op_sel[0];
  assign fwd_b       = op_sel[1];
  assign pc_we       = !stall_w;
  assign ifid_we     = !stall_w;
  assign idex_bubble = stall_w;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] idex_rs,
  input logic [REG_W-1:0] idex_rt,
  input logic             exm_wr,
  input logic [REG_W-1:0] exm_rd,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             pc_we,
  input logic             ifid_we,
  input logic             idex_bubble,
  input logic             ifid_flush,
  input logic             stall,
  input logic             redir
);
  p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a != 2'b11 && fwd_b != 2'b11);

  p_exm_wins_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_wr && exm_rd != '0 && exm_rd == idex_rs) |-> fwd_a == 2'b10);

  p_exm_wins_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_wr && exm_rd != '0 && exm_rd == idex_rt) |-> fwd_b == 2'b10);

  p_no_zero_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b00 |-> idex_rs != '0) and (fwd_b != 2'b00 |-> idex_rt != '0));

  p_freeze_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_we && !ifid_we && idex_bubble));

  p_freeze_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> (pc_we && ifid_we && !idex_bubble));

  p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  p_flush_yields_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_we |-> !ifid_flush);

  p_flush_on_redir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (redir && pc_we) |-> ifid_flush);
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .idex_rs     (idex_rs),
  .idex_rt     (idex_rt),
  .exm_wr      (exm_wr),
  .exm_rd      (exm_rd),
  .fwd_a       (fwd_a),
  .fwd_b       (fwd_b),
  .pc_we       (pc_we),
  .ifid_we     (ifid_we),
  .idex_bubble (idex_bubble),
  .ifid_flush  (ifid_flush),
  .stall       (stall_w),
  .redir       (redir_w)
);

// File: tb/pipe_hazard_ctrl_bench.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_bench;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, exm_rd, mwb_rd;
  logic         idex_memrd, exm_wr, mwb_wr, jump_id, brtaken_id;
  logic [1:0]   fwd_a, fwd_b;
  logic         pc_we, ifid_we, idex_bubble, ifid_flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pipe_hazard_ctrl #(.REG_W(W)) u_pipe_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
    .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_memrd(idex_memrd),
    .exm_wr(exm_wr), .exm_rd(exm_rd), .mwb_wr(mwb_wr), .mwb_rd(mwb_rd),
    .jump_id(jump_id), .brtaken_id(brtaken_id),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we), .ifid_we(ifid_we),
    .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
  );

  // Control word order: {pc_we, ifid_we, idex_bubble, ifid_flush}
  localparam logic [3:0] CTL_RUN   = 4'b1100;
  localparam logic [3:0] CTL_STALL = 4'b0010;
  localparam logic [3:0] CTL_FLUSH = 4'b1101;

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_sel(input string req, input string what,
                           input logic [1:0] ea, input logic [1:0] eb);
    check(req, {what, " A"}, {2'b00, fwd_a}, {2'b00, ea});
    check(req, {what, " B"}, {2'b00, fwd_b}, {2'b00, eb});
  endtask

  function automatic logic [3:0] ctl();
    return {pc_we, ifid_we, idex_bubble, ifid_flush};
  endfunction

  task automatic clear_inputs();
    ifid_rs = '0; ifid_rt = '0; idex_rs = '0; idex_rt = '0;
    exm_rd = '0; mwb_rd = '0; idex_memrd = 1'b0; exm_wr = 1'b0;
    mwb_wr = 1'b0; jump_id = 1'b0; brtaken_id = 1'b0;
  endtask

  // Move to the next quiet point with a clean edge behind us.
  task automatic settle();
    clear_inputs();
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_inputs();
    idex_memrd = 1'b1; idex_rt = 5'd9; ifid_rs = 5'd9;
    #1;
    check("R8", "stall visible during reset", ctl(), CTL_STALL);
    @(negedge clk); rst_n = 1'b1;
    settle();
    #1;
    check_sel("R1", "idle select", 2'b00, 2'b00);
    check("R7", "idle control", ctl(), CTL_RUN);
  endtask

  task automatic t_exm_path();
    settle();
    exm_wr = 1'b1; exm_rd = 5'd3; idex_rs = 5'd3; idex_rt = 5'd4;
    #1; check_sel("R2", "exm to A only", 2'b10, 2'b00);
    idex_rt = 5'd3;
    #1; check_sel("R2", "exm to both", 2'b10, 2'b10);
    exm_wr = 1'b0;
    #1; check_sel("R2", "exm not writing", 2'b00, 2'b00);
  endtask

  task automatic t_zero_reg();
    settle();
    exm_wr = 1'b1; exm_rd = '0; mwb_wr = 1'b1; mwb_rd = '0;
    idex_rs = '0; idex_rt = '0;
    #1; check_sel("R3", "zero dest both stages", 2'b00, 2'b00);
    exm_wr = 1'b0;
    #1; check_sel("R3", "zero dest mwb only", 2'b00, 2'b00);
  endtask

  task automatic t_mwb_path();
    settle();
    mwb_wr = 1'b1; mwb_rd = 5'd5; idex_rs = 5'd6; idex_rt = 5'd5;
    #1; check_sel("R4", "mwb to B", 2'b00, 2'b01);
    exm_wr = 1'b1; exm_rd = 5'd5;
    #1; check_sel("R4", "exm over mwb", 2'b00, 2'b10);
    exm_wr = 1'b0;
    #1; check_sel("R4", "exm match but not writing", 2'b00, 2'b01);
    exm_wr = 1'b1; exm_rd = 5'd6;
    #1; check_sel("R5", "A from exm B from mwb", 2'b10, 2'b01);
    mwb_rd = 5'd6; exm_rd = 5'd5;
    #1; check_sel("R5", "A from mwb B from exm", 2'b01, 2'b10);
  endtask

  task automatic t_load_use();
    settle();
    idex_memrd = 1'b1; idex_rt = 5'd7; ifid_rs = 5'd7; ifid_rt = 5'd2;
    #1; check("R6", "load hits rs", ctl(), CTL_STALL);
    settle();
    idex_memrd = 1'b1; idex_rt = 5'd7; ifid_rs = 5'd1; ifid_rt = 5'd7;
    #1; check("R6", "load hits rt", ctl(), CTL_STALL);
    settle();
    idex_memrd = 1'b0; idex_rt = 5'd7; ifid_rs = 5'd7;
    #1; check("R6", "non-load same reg", ctl(), CTL_RUN);
    idex_memrd = 1'b1; ifid_rs = 5'd8; ifid_rt = 5'd9;
    #1; check("R6", "load no match", ctl(), CTL_RUN);
    settle();
    idex_memrd = 1'b1; idex_rt = '0; ifid_rs = '0; ifid_rt = 5'd4;
    #1; check("R6", "load to reg 0 still stalls", ctl(), CTL_STALL);
  endtask

  task automatic t_single_stall();
    settle();
    idex_memrd = 1'b1; idex_rt = 5'd12; ifid_rt = 5'd12;
    #1; check("R7", "first cycle frozen", ctl(), CTL_STALL);
    @(negedge clk); #1;
    check("R8", "held request second cycle", ctl(), CTL_RUN);
    // Consumer now in execute, load result sitting in write-back.
    @(negedge clk);
    clear_inputs();
    mwb_wr = 1'b1; mwb_rd = 5'd12; idex_rs = 5'd3; idex_rt = 5'd12;
    #1; check_sel("R4", "load value after stall", 2'b00, 2'b01);
  endtask

  task automatic t_redirect();
    settle();
    jump_id = 1'b1;
    #1; check("R9", "jump flush", ctl(), CTL_FLUSH);
    jump_id = 1'b0; brtaken_id = 1'b1;
    #1; check("R9", "taken branch flush", ctl(), CTL_FLUSH);
    brtaken_id = 1'b0;
    #1; check("R9", "no redirect", ctl(), CTL_RUN);
  endtask

  task automatic t_stall_vs_flush();
    settle();
    jump_id = 1'b1; idex_memrd = 1'b1; idex_rt = 5'd14; ifid_rs = 5'd14;
    #1; check("R10", "stall suppresses flush", ctl(), CTL_STALL);
    @(negedge clk);
    idex_memrd = 1'b0; idex_rt = '0;
    #1; check("R10", "flush after stall", ctl(), CTL_FLUSH);
  endtask

  initial begin
    t_reset();
    t_exm_path();
    t_zero_reg();
    t_mwb_path();
    t_load_use();
    t_single_stall();
    t_redirect();
    t_stall_vs_flush();
    settle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule